// File: doc/BRIEF.md
# Oversampled Sample Clock Synchronizer

This block turns a shared oversampling timebase into a common sample clock for a group of oversampling converters. Each timebase arrives as a one-cycle tick strobe in the system clock domain, and a mask reports which timebases are present. A start request either names a timebase or asks for automatic choice. Automatic choice takes the fastest timebase that is present. The request also carries an integer divisor. An accepted request claims one of at most two timebase groups.

Once a group is claimed, it waits for the next tick of its timebase. It then drives a sync pulse to every converter in the group, so that all their decimation filters reset together. A fixed number of ticks after the sync pulse ends, the group emits its first sample pulse. After that, it emits one sample pulse every divisor ticks. The same sample pulse also serves as the conversion trigger for non-oversampling converters in the same task.

A stop request frees a group. Requests use plain single-cycle control pins; there is no data stream and no back-pressure. Every request receives exactly one answer, one cycle later.

Top module: `osclk_sync`

## Requirements
- R1: While reset is held and in the cycle after it is released, every pulse output, every group-active bit, and the ack, reject, code and group outputs are all zero.
- R2: A start request whose divisor is 0 or 1 is rejected. One cycle later, req_rej is 1 and req_code is 1. No group becomes active. This check takes priority over the timebase and capacity checks.
- R3: With automatic choice, the timebase with the lowest index among those present is taken, because index 0 is the fastest. If no timebase is present, the request is rejected with req_code 2.
- R4: With an explicit choice of a timebase that is not present, the request is rejected with req_code 2.
- R5: A valid request is answered one cycle later with req_ack 1, req_code 0 and req_grp equal to the lowest-numbered free group, and that group's active bit goes to 1 in the same cycle.
- R6: When both groups are active, a further valid request is rejected with req_code 3, and the running groups are left undisturbed.
- R7: An active group raises its sync pulse one cycle after the first tick of its timebase that follows acceptance. The pulse stays high until one cycle after the next tick, which is exactly one timebase period.
- R8: The first sample pulse appears LEAD_TICKS ticks after the tick that ended the sync pulse. Each sample pulse is one clock wide and never coincides with sync.
- R9: After the first sample pulse, the group emits a sample pulse every divisor ticks of its timebase.
- R10: A stop request for a group clears its active bit, its sync pulse and its sample pulses in the next cycle, and the group can be claimed again.
- R11: The two groups run independently, each on its own timebase and with its own divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_present | input | NUM_TB | Timebase present mask; index 0 is the fastest |
| tb_tick | input | NUM_TB | One-cycle tick strobe for each timebase |
| start_req | input | 1 | Start request strobe |
| start_auto | input | 1 | 1: pick the fastest present timebase automatically |
| start_tb | input | TB_W | Explicit timebase index, used when start_auto is 0 |
| start_div | input | DIV_W | Integer divisor from timebase ticks to sample pulses |
| stop_req | input | 1 | Stop request strobe |
| stop_grp | input | GRP_W | Group to stop |
| req_ack | output | 1 | Request accepted (one cycle after start_req) |
| req_rej | output | 1 | Request rejected (one cycle after start_req) |
| req_code | output | 2 | 0 ok, 1 bad divisor, 2 timebase absent, 3 no free group |
| req_grp | output | GRP_W | Group claimed by an accepted request |
| grp_active | output | NUM_GRP | Group running |
| sync_pulse | output | NUM_GRP | Converter reset pulse per group |
| samp_pulse | output | NUM_GRP | Sample clock / conversion trigger per group |

## Verification
The bench builds the block with three timebases whose ticks repeat every 3, 5 and 7 clocks. It uses two groups, an 8-bit divisor and LEAD_TICKS of 3. With the ticks spaced this way, sync width, lead delay and sample period each become a distinct number of clocks, so an off-by-one tick in any counter shows up at once. Having three timebases against two groups lets the bench reach automatic choice, explicit choice of an absent timebase, and rejection for lack of a free group, all within one run.

// File: rtl/osclk_pkg.sv
package osclk_pkg;
  typedef enum logic [2:0] {
    G_IDLE = 3'd0,
    G_ARM  = 3'd1,
    G_SYNC = 3'd2,
    G_LEAD = 3'd3,
    G_RUN  = 3'd4
  } grp_st_e;

  typedef enum logic [1:0] {
    REJ_NONE = 2'd0,
    REJ_DIV  = 2'd1,
    REJ_TB   = 2'd2,
    REJ_FULL = 2'd3
  } rej_e;
endpackage

// File: rtl/osclk_tb_pick.sv
module osclk_tb_pick #(
  parameter int NUM_TB = 3,
  localparam int TB_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1
) (
  input  logic [NUM_TB-1:0] tb_present,
  input  logic              auto_en,
  input  logic [TB_W-1:0]   sel,
  output logic [TB_W-1:0]   pick_idx,
  output logic              pick_ok
);
  logic [TB_W-1:0] low_idx;
  logic            low_ok;

  // lowest present index is the fastest timebase
  always_comb begin
    low_idx = '0;
    low_ok  = 1'b0;
    for (int i = NUM_TB - 1; i >= 0; i--) begin
      if (tb_present[i]) begin
        low_idx = TB_W'(i);
        low_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    if (auto_en) begin
      pick_idx = low_idx;
      pick_ok  = low_ok;
    end else begin
      pick_idx = sel;
      pick_ok  = (int'(sel) < NUM_TB) && tb_present[sel];
    end
  end
endmodule

// File: rtl/osclk_grp_alloc.sv
module osclk_grp_alloc #(
  parameter int NUM_GRP = 2,
  localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic [NUM_GRP-1:0] busy,
  output logic [GRP_W-1:0]   free_idx,
  output logic               free_ok
);
  always_comb begin
    free_idx = '0;
    free_ok  = 1'b0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (!busy[g]) begin
        free_idx = GRP_W'(g);
        free_ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/osclk_grp_seq.sv
module osclk_grp_seq
  import osclk_pkg::*;
#(
  parameter int NUM_TB     = 3,
  parameter int DIV_W      = 8,
  parameter int LEAD_TICKS = 3,
  localparam int TB_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_TB-1:0] tb_tick,
  input  logic              load,
  input  logic [TB_W-1:0]   load_tb,
  input  logic [DIV_W-1:0]  load_div,
  input  logic              stop,
  output logic              active,
  output logic              sync_o,
  output logic              samp_o
);
  localparam logic [DIV_W-1:0] LEAD_LAST = DIV_W'(LEAD_TICKS - 1);

  grp_st_e          st_q;
  logic [TB_W-1:0]  tb_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = tb_tick[tb_q];
  assign active = (st_q != G_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= G_IDLE;
      tb_q   <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      sync_o <= 1'b0;
      samp_o <= 1'b0;
    end else begin
      samp_o <= 1'b0;
      if (stop) begin
        st_q   <= G_IDLE;
        sync_o <= 1'b0;
        cnt_q  <= '0;
      end else if (load) begin
        st_q  <= G_ARM;
        tb_q  <= load_tb;
        div_q <= load_div;
        cnt_q <= '0;
      end else if (tick) begin
        unique case (st_q)
          G_ARM: begin
            st_q   <= G_SYNC;
            sync_o <= 1'b1;
          end
          G_SYNC: begin
            st_q   <= G_LEAD;
            sync_o <= 1'b0;
            cnt_q  <= '0;
          end
          G_LEAD: begin
            if (cnt_q == LEAD_LAST) begin
              st_q   <= G_RUN;
              samp_o <= 1'b1;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + DIV_W'(1);
            end
          end
          G_RUN: begin
            if (cnt_q == div_q - DIV_W'(1)) begin
              samp_o <= 1'b1;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + DIV_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: sync only ever starts on a tick of the chosen timebase
  assert_sync_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(tick));
  // R9: every sample pulse follows a timebase tick
  assert_samp_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |-> $past(tick));
  // R8: sample and sync never overlap
  assert_samp_sync_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_o && sync_o));
  // R8: sample pulse is one clock wide
  assert_samp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |=> !samp_o);
  // R10: a stop leaves the group silent
  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!active && !sync_o && !samp_o));
endmodule

// File: rtl/osclk_sync.sv
module osclk_sync
  import osclk_pkg::*;
#(
  parameter int NUM_TB     = 3,
  parameter int NUM_GRP    = 2,
  parameter int DIV_W      = 8,
  parameter int LEAD_TICKS = 3,
  localparam int TB_W  = (NUM_TB > 1) ? $clog2(NUM_TB) : 1,
  localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TB-1:0]  tb_present,
  input  logic [NUM_TB-1:0]  tb_tick,
  input  logic               start_req,
  input  logic               start_auto,
  input  logic [TB_W-1:0]    start_tb,
  input  logic [DIV_W-1:0]   start_div,
  input  logic               stop_req,
  input  logic [GRP_W-1:0]   stop_grp,
  output logic               req_ack,
  output logic               req_rej,
  output logic [1:0]         req_code,
  output logic [GRP_W-1:0]   req_grp,
  output logic [NUM_GRP-1:0] grp_active,
  output logic [NUM_GRP-1:0] sync_pulse,
  output logic [NUM_GRP-1:0] samp_pulse
);
  logic [TB_W-1:0]  pick_idx;
  logic             pick_ok;
  logic [GRP_W-1:0] free_idx;
  logic             free_ok;
  logic             div_ok;
  rej_e             code_d;
  logic             accept;

  osclk_tb_pick #(.NUM_TB(NUM_TB)) u_pick (
    .tb_present(tb_present),
    .auto_en   (start_auto),
    .sel       (start_tb),
    .pick_idx  (pick_idx),
    .pick_ok   (pick_ok)
  );

  osclk_grp_alloc #(.NUM_GRP(NUM_GRP)) u_alloc (
    .busy    (grp_active),
    .free_idx(free_idx),
    .free_ok (free_ok)
  );

  assign div_ok = (start_div > DIV_W'(1));

  always_comb begin
    if (!div_ok)       code_d = REJ_DIV;
    else if (!pick_ok) code_d = REJ_TB;
    else if (!free_ok) code_d = REJ_FULL;
    else               code_d = REJ_NONE;
  end

  assign accept = start_req && (code_d == REJ_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_ack  <= 1'b0;
      req_rej  <= 1'b0;
      req_code <= 2'd0;
      req_grp  <= '0;
    end else begin
      req_ack  <= accept;
      req_rej  <= start_req && (code_d != REJ_NONE);
      req_code <= start_req ? code_d : REJ_NONE;
      req_grp  <= accept ? free_idx : '0;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    osclk_grp_seq #(
      .NUM_TB    (NUM_TB),
      .DIV_W     (DIV_W),
      .LEAD_TICKS(LEAD_TICKS)
    ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tb_tick (tb_tick),
      .load    (accept && (free_idx == GRP_W'(g))),
      .load_tb (pick_idx),
      .load_div(start_div),
      .stop    (stop_req && (stop_grp == GRP_W'(g))),
      .active  (grp_active[g]),
      .sync_o  (sync_pulse[g]),
      .samp_o  (samp_pulse[g])
    );
  end

  // R5: an answer is never both accept and reject
  assert_ack_rej_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && req_rej));
  // R5: answers only follow a request
  assert_answer_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack || req_rej) |-> $past(start_req));
  // R2: accepted divisors are at least 2
  assert_div_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ($past(start_div) > DIV_W'(1)));
  // R6: a full rejection means every group was busy
  assert_full_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rej && req_code == 2'd3) |-> (&$past(grp_active)));
endmodule

// File: tb/test_osclk_sync.sv
module test_osclk_sync;
  localparam int NTB = 3;
  localparam int NG = 2;
  localparam int DW = 8;
  localparam int LEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NTB-1:0] tb_present = '0;
  logic [NTB-1:0] tb_tick = '0;
  logic start_req = 1'b0;
  logic start_auto = 1'b0;
  logic [1:0] start_tb = '0;
  logic [DW-1:0] start_div = '0;
  logic stop_req = 1'b0;
  logic [0:0] stop_grp = '0;
  logic req_ack, req_rej;
  logic [1:0] req_code;
  logic [0:0] req_grp;
  logic [NG-1:0] grp_active, sync_pulse, samp_pulse;

  osclk_sync #(.NUM_TB(NTB), .NUM_GRP(NG), .DIV_W(DW), .LEAD_TICKS(LEAD)) i_osclk_sync (
    .clk(clk), .rst_n(rst_n), .tb_present(tb_present), .tb_tick(tb_tick),
    .start_req(start_req), .start_auto(start_auto), .start_tb(start_tb),
    .start_div(start_div), .stop_req(stop_req), .stop_grp(stop_grp),
    .req_ack(req_ack), .req_rej(req_rej), .req_code(req_code), .req_grp(req_grp),
    .grp_active(grp_active), .sync_pulse(sync_pulse), .samp_pulse(samp_pulse)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int per [NTB] = '{3, 5, 7};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NTB; i++) tb_tick[i] <= ((cyc % per[i]) == 0);
  end

  // behavioural reference model: 0 idle, 1 armed, 2 sync, 3 lead, 4 run
  int m_st [NG], m_cnt [NG], m_tb [NG], m_div [NG];
  bit e_sync [NG], e_samp [NG];
  bit e_ack, e_rej;
  int e_code, e_grp;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        m_st[g] = 0; m_cnt[g] = 0; m_tb[g] = 0; m_div[g] = 0;
        e_sync[g] = 0; e_samp[g] = 0;
      end
      e_ack = 0; e_rej = 0; e_code = 0; e_grp = 0;
    end else begin
      bit busy [NG];
      int code, tbi, fg;
      for (int g = 0; g < NG; g++) begin
        busy[g] = (m_st[g] != 0);
        e_samp[g] = 0;
        if (stop_req && int'(stop_grp) == g) begin
          m_st[g] = 0; e_sync[g] = 0; m_cnt[g] = 0;
        end else if (m_st[g] != 0 && tb_tick[m_tb[g]]) begin
          if (m_st[g] == 1) begin m_st[g] = 2; e_sync[g] = 1; end
          else if (m_st[g] == 2) begin m_st[g] = 3; e_sync[g] = 0; m_cnt[g] = 0; end
          else begin
            m_cnt[g]++;
            if (m_cnt[g] == ((m_st[g] == 3) ? LEAD : m_div[g])) begin
              e_samp[g] = 1; m_cnt[g] = 0; m_st[g] = 4;
            end
          end
        end
      end
      e_ack = 0; e_rej = 0; e_code = 0; e_grp = 0;
      if (start_req) begin
        tbi = -1;
        if (start_auto) begin
          for (int i = NTB - 1; i >= 0; i--) if (tb_present[i]) tbi = i;
        end else if (int'(start_tb) < NTB && tb_present[start_tb]) tbi = int'(start_tb);
        fg = -1;
        for (int g = NG - 1; g >= 0; g--) if (!busy[g]) fg = g;
        if (start_div < 2) code = 1;
        else if (tbi < 0) code = 2;
        else if (fg < 0) code = 3;
        else code = 0;
        e_code = code;
        if (code == 0) begin
          e_ack = 1; e_grp = fg;
          m_st[fg] = 1; m_tb[fg] = tbi; m_div[fg] = int'(start_div); m_cnt[fg] = 0;
        end else e_rej = 1;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ack == e_ack, "R5 ack", req_ack, e_ack);
      check(req_rej == e_rej, "R2 R3 R4 R6 reject", req_rej, e_rej);
      check(int'(req_code) == e_code, "R2 R3 R4 R6 code", req_code, e_code);
      check(int'(req_grp) == e_grp, "R5 grp", req_grp, e_grp);
      for (int g = 0; g < NG; g++) begin
        check(grp_active[g] == (m_st[g] != 0), "R5 R10 active", grp_active[g], m_st[g] != 0);
        check(sync_pulse[g] == e_sync[g], "R7 sync", sync_pulse[g], e_sync[g]);
        check(samp_pulse[g] == e_samp[g], "R8 R9 R11 samp", samp_pulse[g], e_samp[g]);
      end
    end
  end

  task automatic start(input bit au, input int sel, input int dv);
    @(negedge clk);
    start_req = 1; start_auto = au; start_tb = 2'(sel); start_div = DW'(dv);
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic stop(input int g);
    @(negedge clk);
    stop_req = 1; stop_grp = 1'(g);
    @(negedge clk);
    stop_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    idle(100000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, w;
    idle(3);
    check(req_ack == 0 && req_rej == 0 && grp_active == 0 && sync_pulse == 0
          && samp_pulse == 0, "R1 in reset", 1, 0);
    rst_n = 1;
    @(negedge clk);
    check({req_ack, req_rej, req_code, grp_active, sync_pulse, samp_pulse} == 0,
          "R1 after reset", 1, 0);

    tb_present = 3'b111;
    start(1, 0, 1);
    check(req_rej && req_code == 2'd1 && grp_active == 0, "R2 div 1", req_code, 1);
    start(1, 0, 0);
    check(req_rej && req_code == 2'd1, "R2 div 0", req_code, 1);

    tb_present = 3'b000;
    start(1, 0, 4);
    check(req_rej && req_code == 2'd2, "R3 none present", req_code, 2);
    tb_present = 3'b011;
    start(0, 2, 4);
    check(req_rej && req_code == 2'd2, "R4 absent explicit", req_code, 2);

    // auto: tb0 absent, tb1 (5 clocks) taken
    tb_present = 3'b110;
    start(1, 0, 4);
    check(req_ack && req_grp == 0 && grp_active[0], "R5 accept grp0", req_grp, 0);
    n = 0;
    while (!sync_pulse[0] && n < 200) begin @(negedge clk); n++; end
    w = 0;
    while (sync_pulse[0] && w < 200) begin @(negedge clk); w++; end
    check(w == 5, "R7 sync width", w, 5);
    n = 0;
    while (!samp_pulse[0] && n < 200) begin @(negedge clk); n++; end
    check(n == LEAD * 5, "R8 lead delay", n, LEAD * 5);
    @(negedge clk);
    n = 1;
    while (!samp_pulse[0] && n < 200) begin @(negedge clk); n++; end
    check(n == 4 * 5, "R9 period", n, 20);

    // second group on explicit tb2 (7 clocks), divisor 3
    start(0, 2, 3);
    check(req_ack && req_grp == 1, "R11 accept grp1", req_grp, 1);
    start(1, 0, 2);
    check(req_rej && req_code == 2'd3 && grp_active == 2'b11, "R6 third rejected", req_code, 3);
    n = 0;
    while (!samp_pulse[1] && n < 300) begin @(negedge clk); n++; end
    @(negedge clk);
    n = 1;
    while (!samp_pulse[1] && n < 300) begin @(negedge clk); n++; end
    check(n == 3 * 7, "R11 grp1 period", n, 21);

    stop(0);
    check(grp_active[0] == 0 && grp_active[1] == 1, "R10 stopped", grp_active, 2);
    w = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); w += samp_pulse[0] + sync_pulse[0]; end
    check(w == 0, "R10 silent", w, 0);
    start(0, 1, 2);
    check(req_ack && req_grp == 0, "R10 reuse", req_grp, 0);
    idle(200);
    stop(1);
    stop(0);
    idle(10);
    check(grp_active == 0, "R10 all stopped", grp_active, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule